// File: doc/BRIEF.md
# SPI Master Burst Shift Engine

This block is the serial core of an SPI master. A 32-bit control word selects the clock phase and polarity, the bit order, the chip-select behaviour and whether received bytes are kept. Writing that word with its start bit set launches a burst. The engine then clocks out `burst_len` bytes of 8 bits each. The first `tx_len` of those bytes come from a transmit FIFO, and the rest go out as 0x00 filler. Each received byte is pushed into a receive FIFO. When the last byte has been pushed, the engine gives a one-cycle completion pulse and the start bit clears itself.

The serial clock does not come from a divider in this block. Each cycle in which the `tick` input is high advances the serial clock by one half period. Several things sit outside the block: the FIFOs, the tick divider and the register bus that writes the control word.

Top module: `spi_burst_engine`

## Requirements
- R1: Control word fields are: bit 0 phase, bit 1 clock polarity, bit 2 select polarity (1 = active-low, 0 = active-high), bits 5:4 select index, bit 6 manual select, bit 7 manual select level, bit 8 discard receive, bit 12 LSB first, bit 31 start. `ctrl_rdata` returns the stored fields, with all other bits 0. Bit 31 reads 1 exactly while a burst runs.
- R2: A write with bit 31 set while idle samples `burst_len` and `tx_len` and starts a burst. When the burst ends, `done` pulses for one cycle and bit 31 reads 0 from then on. A burst length of 0 completes with no clock edges.
- R3: Only the first `tx_len` bytes are popped from the TX FIFO, and bytes past that point are sent as 0x00. `tx_pop` is never high while `tx_empty` is high.
- R4: `sclk` rests at the clock polarity. Each tick during a byte toggles it, giving 16 edges per byte.
- R5: With phase 0, the first bit is on `mosi` before the first edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With phase 1, `mosi` changes on leading edges and sampling happens on trailing edges.
- R6: Bytes travel MSB first by default. They travel LSB first in both directions when bit 12 is set.
- R7: Each received byte appears on `rx_data` with a one-cycle `rx_push`, during the cycle after its final edge. No push occurs when the discard bit is set.
- R8: While transmit bytes remain but the TX FIFO is empty, `sclk` holds. Shifting resumes once data arrives.
- R9: With automatic select, the indexed line is at its active level while busy and at its inactive level while idle. Non-indexed lines always sit at the inactive level.
- R10: With manual select, the indexed line equals the level bit whether the engine is busy or idle.
- R11: Control writes made while a burst runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word readback with busy in bit 31 |
| burst_len | input | CNT_W | Total bytes to clock |
| tx_len | input | CNT_W | Bytes taken from the TX FIFO |
| tick | input | 1 | Half-period enable for the serial clock |
| tx_empty | input | 1 | TX FIFO empty |
| tx_data | input | WORD_W | TX FIFO head byte |
| tx_pop | output | 1 | TX FIFO pop |
| rx_push | output | 1 | RX FIFO push |
| rx_data | output | WORD_W | Byte to push |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | NUM_CS | Chip-select lines |
| done | output | 1 | Burst complete pulse |

## Verification
The bench covers all four phase and polarity combinations. It ties `miso` back to `mosi`, either straight or inverted. In both cases it rebuilds the byte seen on the wire at each sampling edge. A wrong sampling edge, a swapped bit order or an off-by-one in the edge count shows up as a wire byte that differs from the expected byte. A wrong receive order shows up as a received byte that differs from what was sent. Other vectors set `tx_len` below `burst_len`, so pop counts and 0x00 filler are checked apart from FIFO data. One vector sets the discard flag and is expected to produce no pushes. Directed cases cover a starved FIFO with a write during the burst, a zero-length burst, and automatic and manual select at both polarities.

// File: rtl/spi_be_pkg.sv
package spi_be_pkg;
   localparam int B_PHA  = 0;
   localparam int B_POL  = 1;
   localparam int B_SPOL = 2;
   localparam int B_IDX  = 4;
   localparam int B_MAN  = 6;
   localparam int B_MLVL = 7;
   localparam int B_DROP = 8;
   localparam int B_LSB  = 12;
   localparam int B_GO   = 31;

   typedef struct packed {
      logic       lsb;
      logic       drop;
      logic       mlvl;
      logic       man;
      logic [1:0] idx;
      logic       spol;
      logic       pol;
      logic       pha;
   } xfer_cfg_t;

   function automatic xfer_cfg_t cfg_from_word(input logic [31:0] w);
      xfer_cfg_t c;
      c.pha  = w[B_PHA];
      c.pol  = w[B_POL];
      c.spol = w[B_SPOL];
      c.idx  = w[B_IDX+1:B_IDX];
      c.man  = w[B_MAN];
      c.mlvl = w[B_MLVL];
      c.drop = w[B_DROP];
      c.lsb  = w[B_LSB];
      return c;
   endfunction

   function automatic logic [31:0] word_from_cfg(input xfer_cfg_t c, input logic busy);
      logic [31:0] w;
      w = '0;
      w[B_PHA]           = c.pha;
      w[B_POL]           = c.pol;
      w[B_SPOL]          = c.spol;
      w[B_IDX+1:B_IDX]   = c.idx;
      w[B_MAN]           = c.man;
      w[B_MLVL]          = c.mlvl;
      w[B_DROP]          = c.drop;
      w[B_LSB]           = c.lsb;
      w[B_GO]            = busy;
      return w;
   endfunction
endpackage

// File: rtl/spi_be_shifter.sv
module spi_be_shifter #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              pha,
   input  logic              pol,
   input  logic              lsb,
   input  logic              load,
   input  logic [WORD_W-1:0] load_data,
   input  logic              miso,
   output logic              active,
   output logic              word_done,
   output logic [WORD_W-1:0] rx_word,
   output logic              sclk,
   output logic              mosi
);
   localparam int EDGES = 2 * WORD_W;
   localparam int EW    = $clog2(EDGES);

   logic [EW-1:0]     edge_q;
   logic              lvl_q, active_q, mosi_q, done_q;
   logic [WORD_W-1:0] tx_sh, rx_sh;

   wire fire      = active_q & tick;
   wire is_sample = (edge_q[0] == pha);
   wire last      = (edge_q == EW'(EDGES - 1));
   wire cur_bit   = lsb ? tx_sh[0] : tx_sh[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_q   <= '0;
         lvl_q    <= 1'b0;
         active_q <= 1'b0;
         mosi_q   <= 1'b0;
         done_q   <= 1'b0;
         tx_sh    <= '0;
         rx_sh    <= '0;
      end else begin
         done_q <= 1'b0;
         if (load && !active_q) begin
            active_q <= 1'b1;
            tx_sh    <= load_data;
            edge_q   <= '0;
         end else if (fire) begin
            lvl_q  <= ~lvl_q;
            edge_q <= last ? '0 : edge_q + 1'b1;
            if (is_sample) begin
               rx_sh <= lsb ? {miso, rx_sh[WORD_W-1:1]} : {rx_sh[WORD_W-2:0], miso};
            end else begin
               if (pha) mosi_q <= cur_bit;
               tx_sh <= lsb ? (tx_sh >> 1) : (tx_sh << 1);
            end
            if (last) begin
               active_q <= 1'b0;
               done_q   <= 1'b1;
            end
         end
      end
   end

   assign active    = active_q;
   assign word_done = done_q;
   assign rx_word   = rx_sh;
   assign sclk      = pol ^ lvl_q;
   assign mosi      = pha ? mosi_q : cur_bit;

   // R4
   sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !tick) |=> $stable(sclk));
   // R4
   sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> (sclk == pol));
endmodule

// File: rtl/spi_be_select.sv
module spi_be_select #(
   parameter int NUM_CS = 4,
   localparam int IW    = $clog2(NUM_CS)
) (
   input  logic [IW-1:0]     idx,
   input  logic              spol,
   input  logic              man,
   input  logic              mlvl,
   input  logic              busy,
   output logic [NUM_CS-1:0] cs
);
   logic sel_lvl;
   assign sel_lvl = man ? mlvl : (busy ? ~spol : spol);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_line
      assign cs[i] = (idx == IW'(i)) ? sel_lvl : spol;
   end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
   import spi_be_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int NUM_CS = 4,
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [31:0]       ctrl_wdata,
   output logic [31:0]       ctrl_rdata,
   input  logic [CNT_W-1:0]  burst_len,
   input  logic [CNT_W-1:0]  tx_len,
   input  logic              tick,
   input  logic              tx_empty,
   input  logic [WORD_W-1:0] tx_data,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [WORD_W-1:0] rx_data,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_out,
   output logic              done
);
   localparam int IW = $clog2(NUM_CS);

   if (WORD_W != 8) begin : g_bad_word
      $error("WORD_W must be 8");
   end
   if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
      $error("CNT_W must be 1..24");
   end
   if (NUM_CS < 2 || NUM_CS > 4) begin : g_bad_cs
      $error("NUM_CS must be 2..4");
   end

   xfer_cfg_t        cfg_q;
   logic             busy_q, done_q;
   logic [CNT_W-1:0] left_q, txleft_q;
   logic             sh_active, sh_done;
   logic [WORD_W-1:0] sh_rx;

   wire start     = ctrl_we & ~busy_q & ctrl_wdata[B_GO];
   wire want      = busy_q & ~sh_active & (left_q != '0);
   wire from_fifo = (txleft_q != '0);
   wire load      = want & (~from_fifo | ~tx_empty);
   wire finish    = busy_q & ~sh_active & ~sh_done & (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         left_q   <= '0;
         txleft_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (ctrl_we && !busy_q) cfg_q <= cfg_from_word(ctrl_wdata);
         if (start) begin
            busy_q   <= 1'b1;
            left_q   <= burst_len;
            txleft_q <= tx_len;
         end else if (load) begin
            left_q <= left_q - 1'b1;
            if (from_fifo) txleft_q <= txleft_q - 1'b1;
         end else if (finish) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   spi_be_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .pha       (cfg_q.pha),
      .pol       (cfg_q.pol),
      .lsb       (cfg_q.lsb),
      .load      (load),
      .load_data (from_fifo ? tx_data : '0),
      .miso      (miso),
      .active    (sh_active),
      .word_done (sh_done),
      .rx_word   (sh_rx),
      .sclk      (sclk),
      .mosi      (mosi)
   );

   spi_be_select #(.NUM_CS(NUM_CS)) u_sel (
      .idx  (cfg_q.idx[IW-1:0]),
      .spol (cfg_q.spol),
      .man  (cfg_q.man),
      .mlvl (cfg_q.mlvl),
      .busy (busy_q),
      .cs   (cs_out)
   );

   assign tx_pop     = load & from_fifo;
   assign rx_push    = sh_done & ~cfg_q.drop;
   assign rx_data    = sh_rx;
   assign done       = done_q;
   assign ctrl_rdata = word_from_cfg(cfg_q, busy_q);

   // R3
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> !tx_empty);
   // R7
   push_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> busy_q);
   // R2
   done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!ctrl_rdata[B_GO] && $past(busy_q)));
   // R11
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> $stable(ctrl_rdata));
endmodule

// File: tb/sim_spi_burst_engine.sv
module sim_spi_burst_engine;
   typedef struct packed {
      logic       pha, pol, lsb, drop, inv;
      logic [3:0] burst, txl;
      logic [7:0] seed;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd3, 8'hA5},
      '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 4'd2, 8'h3C},
      '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 4'd1, 8'h81},
      '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 4'd2, 8'h5A},
      '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2, 4'd2, 8'hC3},
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 4'd0, 8'h00}
   };

   logic clk = 0, rst_n = 0;
   logic ctrl_we = 0;
   logic [31:0] ctrl_wdata = '0, ctrl_rdata;
   logic [23:0] burst_len = '0, tx_len = '0;
   logic tick = 0, tx_empty, tx_pop, rx_push, sclk, mosi, miso, done;
   logic [7:0] tx_data, rx_data;
   logic [3:0] cs_out;
   logic inv_q = 0, pha_b = 0, pol_b = 0;

   int errors = 0, checks = 0;
   int fh = 0, ft = 0;
   logic [7:0] fq [32];
   int edges = 0, nb = 0, nw = 0, nr = 0, npop = 0;
   logic [7:0] wacc = '0;
   logic [7:0] wcap [16];
   logic [7:0] rcap [16];
   logic sclk_prev = 0;
   int tdiv = 0;

   always #10 clk = ~clk;

   spi_burst_engine u0 (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .ctrl_rdata(ctrl_rdata), .burst_len(burst_len), .tx_len(tx_len), .tick(tick),
      .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push),
      .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_out(cs_out),
      .done(done)
   );

   assign miso     = mosi ^ inv_q;
   assign tx_empty = (fh == ft);
   assign tx_data  = fq[fh % 32];

   always @(posedge clk) begin
      if (tx_pop) fh <= fh + 1;
      tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
      tick <= (tdiv == 2);
   end

   always @(negedge clk) begin
      if (sclk !== sclk_prev) begin
         edges++;
         if ((sclk_prev == pol_b) != pha_b) begin
            wacc = {wacc[6:0], mosi};
            nb++;
            if (nb == 8) begin
               wcap[nw % 16] = wacc;
               nw++;
               nb = 0;
            end
         end
      end
      sclk_prev = sclk;
      if (rx_push) begin
         rcap[nr % 16] = rx_data;
         nr++;
      end
      if (tx_pop) npop++;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic pha, pol, spol, input logic [1:0] idx,
                                      input logic man, lvl, drop, lsb);
      logic [31:0] w;
      w = '0;
      w[0] = pha; w[1] = pol; w[2] = spol; w[5:4] = idx;
      w[6] = man; w[7] = lvl; w[8] = drop; w[12] = lsb;
      return w;
   endfunction

   function automatic logic [7:0] vbyte(input logic [7:0] seed, input int i);
      return seed + 8'(i * 59);
   endfunction

   function automatic logic [7:0] rev8(input logic [7:0] d);
      logic [7:0] r;
      for (int k = 0; k < 8; k++) r[k] = d[7-k];
      return r;
   endfunction

   task automatic wr_ctrl(input logic [31:0] w);
      @(negedge clk);
      ctrl_we = 1; ctrl_wdata = w;
      @(negedge clk);
      ctrl_we = 0;
   endtask

   task automatic push_tx(input logic [7:0] d);
      fq[ft % 32] = d;
      ft++;
   endtask

   task automatic clear_caps();
      @(posedge clk);
      edges = 0; nb = 0; nw = 0; nr = 0; npop = 0; wacc = '0;
   endtask

   task automatic wait_done(input int lim, output bit ok);
      ok = 0;
      for (int k = 0; k < lim; k++) begin
         @(negedge clk);
         if (done) begin ok = 1; break; end
      end
   endtask

   task automatic run_vec(input vec_t v);
      logic [31:0] w;
      logic [7:0]  d;
      bit ok;
      pha_b = v.pha; pol_b = v.pol; inv_q = v.inv;
      w = mk(v.pha, v.pol, 1'b0, 2'd0, 1'b0, 1'b0, v.drop, v.lsb);
      wr_ctrl(w);
      clear_caps();
      for (int i = 0; i < int'(v.txl); i++) push_tx(vbyte(v.seed, i));
      burst_len = 24'(v.burst); tx_len = 24'(v.txl);
      wr_ctrl(w | 32'h8000_0000);
      wait_done(200, ok);
      chk("R2 done pulse", 32'(ok), 1);
      repeat (2) @(negedge clk);
      chk("R2 start bit cleared", 32'(ctrl_rdata[31]), 0);
      chk("R1 readback", ctrl_rdata, w);
      chk("R4 edge count", edges, 16 * int'(v.burst));
      chk("R3 pop count", npop, int'(v.txl));
      chk("R5 wire byte count", nw, int'(v.burst));
      for (int i = 0; i < int'(v.burst); i++) begin
         d = (i < int'(v.txl)) ? vbyte(v.seed, i) : 8'h00;
         chk(v.lsb ? "R6 lsb wire byte" : "R5 msb wire byte", wcap[i], v.lsb ? rev8(d) : d);
         if (!v.drop) chk("R7 rx byte", rcap[i], d ^ {8{v.inv}});
      end
      chk("R7 rx push count", nr, v.drop ? 0 : int'(v.burst));
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [31:0] w;
      bit ok;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset readback", ctrl_rdata, 0);
      chk("R4 reset sclk", 32'(sclk), 0);
      chk("R9 reset select lines", 32'(cs_out), 0);
      chk("R2 reset done", 32'(done), 0);
      chk("R7 reset push", 32'(rx_push), 0);

      for (int n = 0; n < NV; n++) run_vec(VECS[n]);

      // R2 zero-length burst
      pha_b = 0; pol_b = 0; inv_q = 0;
      wr_ctrl(32'h0);
      clear_caps();
      burst_len = 0; tx_len = 0;
      wr_ctrl(32'h8000_0000);
      wait_done(10, ok);
      chk("R2 zero burst done", 32'(ok), 1);
      chk("R2 zero burst edges", edges, 0);
      @(negedge clk);
      chk("R2 zero burst busy clear", 32'(ctrl_rdata[31]), 0);

      // R8 starved FIFO, R11 write while busy
      clear_caps();
      burst_len = 2; tx_len = 2;
      wr_ctrl(32'h8000_0000);
      repeat (60) @(negedge clk);
      chk("R8 no edges while starved", edges, 0);
      chk("R8 still busy", 32'(ctrl_rdata[31]), 1);
      wr_ctrl(mk(1'b1, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1) | 32'h8000_0000);
      chk("R11 busy write ignored", ctrl_rdata, 32'h8000_0000);
      chk("R11 sclk level kept", 32'(sclk), 0);
      push_tx(8'h96); push_tx(8'h0F);
      wait_done(300, ok);
      chk("R8 resumed done", 32'(ok), 1);
      chk("R8 edges after resume", edges, 32);
      chk("R8 first byte", wcap[0], 8'h96);
      chk("R8 second byte", wcap[1], 8'h0F);

      // R9 automatic select, active-low on line 2
      w = mk(1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
      wr_ctrl(w);
      chk("R9 idle active-low", 32'(cs_out), 32'hF);
      burst_len = 1; tx_len = 0;
      wr_ctrl(w | 32'h8000_0000);
      repeat (3) @(negedge clk);
      chk("R9 busy active-low", 32'(cs_out), 32'hB);
      wait_done(200, ok);
      @(negedge clk);
      chk("R9 after burst", 32'(cs_out), 32'hF);
      // R9 automatic select, active-high on line 1
      w = mk(1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
      wr_ctrl(w);
      chk("R9 idle active-high", 32'(cs_out), 32'h0);
      wr_ctrl(w | 32'h8000_0000);
      repeat (3) @(negedge clk);
      chk("R9 busy active-high", 32'(cs_out), 32'h2);
      wait_done(200, ok);

      // R10 manual select
      wr_ctrl(mk(1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0));
      chk("R10 manual low", 32'(cs_out), 32'hD);
      wr_ctrl(mk(1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0));
      chk("R10 manual high", 32'(cs_out), 32'hF);
      wr_ctrl(mk(1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0));
      chk("R10 manual high spol0", 32'(cs_out), 32'h2);
      wr_ctrl(mk(1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0) | 32'h8000_0000);
      repeat (3) @(negedge clk);
      chk("R10 manual level while busy", 32'(cs_out), 32'h2);
      wait_done(200, ok);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule